// File: doc/BRIEF.md
# Eight-Bank Interleaved Word Memory

This block is a read-only word memory split across eight independent banks. Consecutive 4-byte words fall in consecutive banks, so a requester streaming through a 32-byte line touches every bank once. A request travels over a one-cycle address transfer stage. The chosen bank then spends `LATENCY` cycles producing the word, and the word crosses a one-cycle data transfer stage. A single read therefore returns `LATENCY+2` cycles after it is issued.

Because the banks work independently, a new word address may be accepted every cycle. The eight words of a line come back on consecutive cycles, the last one `LATENCY+9` cycles after the first address was issued. Addresses and data use separate paths, so new requests and returning words can be active in the same cycle. A bank that is still working blocks only requests aimed at that bank. Responses always leave in the order the requests were accepted. A preload port fills the backing store for testing.

Top module: `interleaved_word_mem`

## Requirements
- R1: During reset and in the first cycle after it, `rspValid` is 0, and `reqReady` is 1 for every bank.
- R2: The byte address is split as: bits [4:2] select the bank, bits [ADDR_W-1:5] select the row inside the bank, and bits [1:0] have no effect on which word is returned.
- R3: A single accepted request returns its word with `rspValid` high exactly `LATENCY+2` cycles after the cycle in which it was accepted.
- R4: Eight requests to the consecutive words of one line, presented on consecutive cycles, are all accepted without a stall. Their words return on eight consecutive cycles, from `LATENCY+2` to `LATENCY+9` after the first was accepted.
- R5: In a cycle where a word is being returned, a new request can still be accepted. Sixteen back-to-back word requests stream with no stall.
- R6: After a bank accepts a request in cycle c, `reqReady` is 0 for a request to the same bank in cycles c+1 through c+LATENCY-1, and is 1 again in cycle c+LATENCY.
- R7: While one bank is busy, requests to the other banks are accepted without a stall.
- R8: Responses leave strictly in acceptance order. Each carries the word stored at its requested address and is marked by `rspValid` for one cycle.
- R9: A preload write with `preWe` high stores `preData` at word index `preAddr`. Bits [2:0] of the index give the bank and the upper bits give the row. A later read of byte address `4*preAddr` returns that value.
- R10: `rspValid` stays 0 in every cycle for which no accepted request is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A read request is presented |
| reqAddr | input | ADDR_W | Byte address of the requested word |
| reqReady | output | 1 | The presented request is accepted this cycle |
| rspValid | output | 1 | `rspData` carries a returned word |
| rspData | output | WORD_W | Returned word |
| preWe | input | 1 | Preload write strobe |
| preAddr | input | ADDR_W-2 | Word index for the preload write |
| preData | input | WORD_W | Word written by the preload port |

## Verification
The hardest situation to reach from the ports is a second request to the same bank that lands inside that bank's busy window, while the other banks keep streaming. The stall must last exactly `LATENCY-1` cycles, and the earlier word held in the bank must not be overwritten before it crosses to the data stage. The stimulus issues a request to bank 0 and immediately presents another bank-0 address. It counts the stalled cycles and then checks both returned words for value and timing. A separate sixteen-word stream forces a request to be accepted in the very cycle the first word of the stream is returned, which shows that address and data traffic do not interfere.

// File: rtl/iwm_pkg.sv
package iwm_pkg;

  localparam int NUM_BANKS  = 8;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int WORD_BYTES = 4;
  localparam int OFFSET_W   = $clog2(WORD_BYTES);

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [NUM_BANKS-1:0] bankLoad;   // one-hot: bank latches its row word
    logic                 capture;    // data stage loads a word
    logic [BANK_W-1:0]    captureSel; // bank whose held word is taken
  } strobes_t;

endpackage

// File: rtl/iwm_bank.sv
module iwm_bank #(
  parameter int ROW_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              preWe,
  input  logic [ROW_W-1:0]  preRow,
  input  logic [WORD_W-1:0] preData,
  input  logic              load,
  input  logic [ROW_W-1:0]  loadRow,
  output logic [WORD_W-1:0] holdWord
);

  localparam int DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] store [DEPTH];

  // The held word stays stable until the next load. The control
  // guarantees the data stage has taken it by then.
  always_ff @(posedge clk) begin
    if (preWe) store[preRow] <= preData;
    if (load)  holdWord      <= store[loadRow];
  end

endmodule

// File: rtl/iwm_datapath.sv
module iwm_datapath
  import iwm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                stb,
  input  logic [ROW_W-1:0]        loadRow,
  input  logic                    preWe,
  input  logic [BANK_W+ROW_W-1:0] preWordAddr,
  input  logic [WORD_W-1:0]       preData,
  output logic                    rspValid,
  output logic [WORD_W-1:0]       rspData
);

  logic [BANK_W-1:0] preBank;
  logic [ROW_W-1:0]  preRow;
  logic [WORD_W-1:0] holdWords [NUM_BANKS];
  logic [WORD_W-1:0] selWord;

  assign preBank = preWordAddr[BANK_W-1:0];
  assign preRow  = preWordAddr[BANK_W+ROW_W-1:BANK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    iwm_bank #(.ROW_W(ROW_W), .WORD_W(WORD_W)) i_bank (
      .clk      (clk),
      .preWe    (preWe && (preBank == BANK_W'(b))),
      .preRow   (preRow),
      .preData  (preData),
      .load     (stb.bankLoad[b]),
      .loadRow  (loadRow),
      .holdWord (holdWords[b])
    );
  end

  assign selWord = holdWords[stb.captureSel];

  // Data transfer stage: one register between the banks and the port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) rspData <= selWord;
    end
  end

endmodule

// File: rtl/iwm_ctrl.sv
module iwm_ctrl
  import iwm_pkg::*;
#(
  parameter int LATENCY = 4,
  parameter int ROW_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  output logic              reqReady,
  output strobes_t          stb,
  output logic [ROW_W-1:0]  loadRow
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0]  resCnt [NUM_BANKS];
  logic              issue;
  logic              stgValid;
  logic [BANK_W-1:0] stgBank;
  logic [ROW_W-1:0]  stgRow;
  logic [LATENCY-1:0]             tagValid;
  logic [LATENCY-1:0][BANK_W-1:0] tagBank;

  assign reqReady = (resCnt[reqBank] == '0);
  assign issue    = reqValid && reqReady;

  // Per-bank reservation: a request to the bank accepted in cycle c
  // keeps the bank closed to new requests until cycle c+LATENCY.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) resCnt[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (issue && (reqBank == BANK_W'(b)))
          resCnt[b] <= CNT_W'(LATENCY - 1);
        else if (resCnt[b] != '0)
          resCnt[b] <= resCnt[b] - 1'b1;
      end
    end
  end

  // Address transfer stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      stgBank  <= '0;
      stgRow   <= '0;
    end else begin
      stgValid <= issue;
      if (issue) begin
        stgBank <= reqBank;
        stgRow  <= reqRow;
      end
    end
  end

  // Tag line follows each access through the bank latency so that the
  // data stage knows which bank to take from, in issue order.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagValid <= '0;
      tagBank  <= '0;
    end else begin
      tagValid[0] <= stgValid;
      tagBank[0]  <= stgBank;
      for (int k = 1; k < LATENCY; k++) begin
        tagValid[k] <= tagValid[k-1];
        tagBank[k]  <= tagBank[k-1];
      end
    end
  end

  always_comb begin
    stb.bankLoad = '0;
    if (stgValid) stb.bankLoad[stgBank] = 1'b1;
    stb.capture    = tagValid[LATENCY-1];
    stb.captureSel = tagBank[LATENCY-1];
  end

  assign loadRow = stgRow;

endmodule

// File: rtl/interleaved_word_mem.sv
module interleaved_word_mem
  import iwm_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WORD_W  = 32,
  parameter int LATENCY = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   reqReady,
  output logic                   rspValid,
  output logic [WORD_W-1:0]      rspData,
  input  logic                   preWe,
  input  logic [ADDR_W-OFFSET_W-1:0] preAddr,
  input  logic [WORD_W-1:0]      preData
);

  localparam int ROW_W = ADDR_W - OFFSET_W - BANK_W;

  strobes_t          stb;
  logic [ROW_W-1:0]  loadRow;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic              unusedOffsetBits;

  assign reqBank          = reqAddr[OFFSET_W+BANK_W-1:OFFSET_W];
  assign reqRow           = reqAddr[ADDR_W-1:OFFSET_W+BANK_W];
  assign unusedOffsetBits = ^reqAddr[OFFSET_W-1:0];

  iwm_ctrl #(.LATENCY(LATENCY), .ROW_W(ROW_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .reqReady (reqReady),
    .stb      (stb),
    .loadRow  (loadRow)
  );

  iwm_datapath #(.ROW_W(ROW_W), .WORD_W(WORD_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .loadRow     (loadRow),
    .preWe       (preWe),
    .preWordAddr (preAddr),
    .preData     (preData),
    .rspValid    (rspValid),
    .rspData     (rspData)
  );

endmodule

// File: rtl/iwm_chk.sv
module iwm_chk
  import iwm_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int WORD_W  = 32,
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              rspValid,
  input logic [WORD_W-1:0] rspData
);

  logic [LATENCY+1:0] issuePipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issuePipe <= '0;
    end else begin
      issuePipe[0] <= reqValid && reqReady;
      for (int k = 1; k <= LATENCY + 1; k++) issuePipe[k] <= issuePipe[k-1];
    end
  end

  // R3 / R10: a response appears exactly LATENCY+2 cycles after each accept.
  p_rsp_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == issuePipe[LATENCY+1]);

  // R1: no response in the first cycle after reset.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !rspValid);

  // R8: a returned word never carries unknown bits.
  p_rsp_known_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !$isunknown(rspData));

  // R6: the bank just accepted cannot take another request next cycle.
  if (LATENCY > 1) begin : g_busy
    p_same_bank_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(reqValid && reqReady) && reqValid &&
       (reqAddr[OFFSET_W+BANK_W-1:OFFSET_W] ==
        $past(reqAddr[OFFSET_W+BANK_W-1:OFFSET_W]))) |-> !reqReady);
  end

endmodule

bind interleaved_word_mem iwm_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LATENCY(LATENCY)
) i_iwm_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspData  (rspData)
);

// File: tb/test_interleaved_word_mem.sv
module test_interleaved_word_mem;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;
  localparam int WORD_W     = 32;
  localparam int LAT        = 4;
  localparam int NWORDS     = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              rspValid;
  logic [WORD_W-1:0] rspData;
  logic              preWe = 1'b0;
  logic [ADDR_W-3:0] preAddr = '0;
  logic [WORD_W-1:0] preData = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [WORD_W-1:0] model [NWORDS];
  logic [WORD_W-1:0] expD [0:511];
  int expT [0:511];
  int qHead = 0;
  int qTail = 0;
  int rspCycle [0:511];
  int rspCount = 0;

  interleaved_word_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LATENCY(LAT))
    i_interleaved_word_mem (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
      .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
      .preWe(preWe), .preAddr(preAddr), .preData(preData));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Response monitor: order, data (R8) and timing (R3); stray words (R10).
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspCycle[rspCount] = cyc;
      rspCount++;
      if (qHead == qTail) begin
        check(1'b0, "R10", "response with nothing due", 1, 0);
      end else begin
        check(rspData == expD[qHead], "R8", "returned word", rspData, expD[qHead]);
        check(cyc == expT[qHead], "R3", "return cycle", cyc, expT[qHead]);
        qHead++;
      end
    end
  end

  function automatic logic [WORD_W-1:0] patt(input int i);
    return 32'hC300_0000 ^ (i * 32'h0001_0307);
  endfunction

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issueReq(input logic [ADDR_W-1:0] a, output int issuedAt,
                          output int stalls);
    stalls = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    #1;
    while (!reqReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    issuedAt = cyc;
    expD[qTail] = model[a >> 2];
    expT[qTail] = cyc + LAT + 2;
    qTail++;
  endtask

  task automatic stopReq();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic preloadWord(input int idx, input logic [WORD_W-1:0] v);
    @(negedge clk);
    preWe   = 1'b1;
    preAddr = (ADDR_W-2)'(idx);
    preData = v;
    model[idx] = v;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic testReset();
    for (int b = 0; b < 8; b++) begin
      reqAddr = ADDR_W'(b * 4);
      #1;
      check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    end
    check(rspValid == 1'b0, "R1", "rspValid after reset", rspValid, 0);
  endtask

  task automatic testPreload();
    for (int i = 0; i < NWORDS; i++) begin
      @(negedge clk);
      preWe   = 1'b1;
      preAddr = (ADDR_W-2)'(i);
      preData = patt(i);
      model[i] = patt(i);
    end
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic testSingle();
    int t, s, n0;
    n0 = rspCount;
    issueReq(9'h024, t, s);
    stopReq();
    waitCycles(LAT + 4);
    check(rspCount == n0 + 1, "R3", "single read count", rspCount, n0 + 1);
    check(rspCycle[n0] == t + LAT + 2, "R3", "single read latency",
          rspCycle[n0], t + LAT + 2);
  endtask

  task automatic testLine();
    int t0, t, s, stallSum, n0;
    n0 = rspCount;
    stallSum = 0;
    t0 = 0;
    for (int k = 0; k < 8; k++) begin
      issueReq(ADDR_W'(9'h040 + k * 4), t, s);
      if (k == 0) t0 = t;
      stallSum += s;
    end
    stopReq();
    waitCycles(LAT + 12);
    check(stallSum == 0, "R4", "line stalls", stallSum, 0);
    check(rspCount == n0 + 8, "R4", "line word count", rspCount, n0 + 8);
    for (int k = 0; k < 8; k++)
      check(rspCycle[n0 + k] == t0 + LAT + 2 + k, "R4", "line return cycle",
            rspCycle[n0 + k], t0 + LAT + 2 + k);
  endtask

  task automatic testOverlap();
    int issueAt [16];
    int s, stallSum, n0;
    n0 = rspCount;
    stallSum = 0;
    for (int k = 0; k < 16; k++) begin
      issueReq(ADDR_W'(9'h100 + k * 4), issueAt[k], s);
      stallSum += s;
    end
    stopReq();
    waitCycles(LAT + 20);
    check(stallSum == 0, "R5", "stream stalls", stallSum, 0);
    check(rspCount == n0 + 16, "R5", "stream word count", rspCount, n0 + 16);
    check(issueAt[LAT + 2] == rspCycle[n0], "R5",
          "request accepted in cycle of first return", issueAt[LAT + 2], rspCycle[n0]);
  endtask

  task automatic testSameBank();
    int c0, t, s;
    issueReq(9'h000, c0, s);
    issueReq(9'h020, t, s);
    stopReq();
    waitCycles(LAT + 6);
    check(s == LAT - 1, "R6", "same-bank stall cycles", s, LAT - 1);
    check(t == c0 + LAT, "R6", "same-bank accept cycle", t, c0 + LAT);
  endtask

  task automatic testOtherBank();
    int t, s, stallSum;
    stallSum = 0;
    issueReq(9'h060, t, s);
    issueReq(9'h064, t, s); stallSum += s;
    issueReq(9'h07C, t, s); stallSum += s;
    issueReq(9'h068, t, s); stallSum += s;
    stopReq();
    waitCycles(LAT + 6);
    check(stallSum == 0, "R7", "other banks stall", stallSum, 0);
  endtask

  task automatic testOrder();
    int t, s, n0;
    n0 = rspCount;
    issueReq(9'h014, t, s);
    issueReq(9'h004, t, s);
    issueReq(9'h01C, t, s);
    issueReq(9'h030, t, s);
    issueReq(9'h008, t, s);
    stopReq();
    waitCycles(LAT + 8);
    check(rspCount == n0 + 5, "R8", "mixed-order count", rspCount, n0 + 5);
    check(qHead == qTail, "R8", "all mixed-order words returned", qHead, qTail);
  endtask

  task automatic testOffset();
    int t, s;
    // Bits [1:0] set: word 18 and word 19 must come back unchanged (R2).
    issueReq(9'h04B, t, s);
    issueReq(9'h04D, t, s);
    issueReq(9'h1F7, t, s);
    stopReq();
    waitCycles(LAT + 6);
    check(qHead == qTail, "R2", "offset-bit reads returned", qHead, qTail);
  endtask

  task automatic testPreloadWrite();
    int t, s;
    preloadWord(50, 32'hDEAD_BEEF);
    issueReq(ADDR_W'(50 * 4), t, s);
    stopReq();
    waitCycles(LAT + 4);
    check(model[50] == 32'hDEAD_BEEF && qHead == qTail, "R9",
          "preloaded word read back", qHead, qTail);
  endtask

  task automatic testIdle();
    int n0;
    n0 = rspCount;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(rspValid == 1'b0, "R10", "idle rspValid", rspValid, 0);
    end
    check(rspCount == n0, "R10", "idle response count", rspCount, n0);
  endtask

  initial begin
    waitCycles(3);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testPreload();
    testSingle();
    testLine();
    testOverlap();
    testSameBank();
    testOtherBank();
    testOrder();
    testOffset();
    testPreloadWrite();
    testIdle();
    check(qHead == qTail, "R8", "all responses drained", qHead, qTail);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", qHead, qTail);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule